// File: doc/BRIEF.md
# Decimating FIR Multiply-Accumulate Cell Array

This block is a chain of multiply-accumulate cells for building FIR filters. One sample word goes to every cell at once. A coefficient word enters the first cell and moves from cell to cell. Each cell multiplies the shared sample by its own current coefficient and adds the product into a 26-bit signed accumulator. A downstream output stage reads every accumulator directly.

Between neighbouring cells the coefficient passes through a delay of one to four registers, chosen by a 2-bit select. This lets the array produce outputs at one half, one third or one quarter of the input rate. The sample and the coefficient each have their own mode input. A mode input selects whether that operand is an 8-bit unsigned value or a 9-bit two's complement value. Each cell has its own clear strobe, which starts a new sum. The coefficient that leaves the last cell is brought out so that a further array can be chained behind this one.

Top module: `firCellArray`

## Requirements
- R1: A synchronous reset sets every accumulator, the sample register and every coefficient register to zero, so `accOut` and `coefCascade` both read 0 after reset.
- R2: When an operand's mode bit is 1, that operand is a 9-bit two's complement value and bit 8 is its sign. The product is signed.
- R3: When an operand's mode bit is 0, only its bits 7:0 are used, as an unsigned value, and bit 8 has no effect. The two mode bits act independently of each other.
- R4: On each clock edge without clear, each cell adds to its accumulator the product of the registered sample and that cell's first coefficient register. Cell k's accumulator sits in bits `accOut[26*k+25:26*k]`.
- R5: On an edge where `accClear[k]` is 1, accumulator k loads the current product in place of the sum. Other cells keep accumulating.
- R6: While `dataEn` is 0, the sample register keeps its value. While it is 1, the register loads `sampleIn` on each edge.
- R7: While `coefEn` is 0, every coefficient register in every cell keeps its value.
- R8: When `coefEn` is 1, cell 0's first register loads `coefIn`. Each later cell's first register loads its neighbour's coefficient after decSel+1 register stages (`decSel` = 00, 01, 10, 11 gives 1, 2, 3, 4 stages).
- R9: `coefCascade` is the last cell's coefficient after decSel+1 stages. A coefficient therefore reaches it 8*(decSel+1) enabled edges after it is presented at `coefIn`.
- R10: Each accumulator holds the exact two's complement sum of up to 511 products of any operand values without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleIn | input | 9 | Sample word shared by all cells |
| coefIn | input | 9 | Coefficient entering cell 0 |
| sampleSigned | input | 1 | 1: sample is 9-bit two's complement, 0: 8-bit unsigned |
| coefSigned | input | 1 | 1: coefficient is 9-bit two's complement, 0: 8-bit unsigned |
| dataEn | input | 1 | Load enable of the sample register |
| coefEn | input | 1 | Shift enable of the coefficient chain |
| decSel | input | 2 | Coefficient delay per cell, minus one |
| accClear | input | 8 | Per-cell strobe: load the product instead of adding it |
| accOut | output | 208 | All accumulators; cell k in bits 26k+25 down to 26k |
| coefCascade | output | 9 | Coefficient leaving the last cell |

## Verification
The hardest case to reach from the ports is a coefficient travelling through all eight cells with four register stages each. That takes 32 enabled edges with no break. The stimulus sends a single nonzero coefficient into an otherwise zero stream with the longest delay selected, and it mixes in phases where the chain is paused. A second hard case is an accumulator close to its 26-bit limit. Here the stimulus applies the largest-magnitude product, -256 times -256, for 500 edges in a row after a clear.

// File: rtl/firCellPkg.sv
package firCellPkg;
  localparam int OPND_W     = 9;
  localparam int PROD_W     = 2 * OPND_W;
  localparam int DEC_STAGES = 4;
  localparam int SEL_W      = $clog2(DEC_STAGES);

  typedef struct packed {
    logic                  loadSample;
    logic                  shiftCoef;
    logic                  sampleSigned;
    logic                  coefSigned;
    logic [DEC_STAGES-1:0] tapSel;
  } cellStrobes_t;
endpackage

// File: rtl/firCellCtrl.sv
module firCellCtrl
  import firCellPkg::*;
(
  input  logic             dataEn,
  input  logic             coefEn,
  input  logic             sampleSigned,
  input  logic             coefSigned,
  input  logic [SEL_W-1:0] decSel,
  output cellStrobes_t     strobes
);
  // decode the delay select into a one-hot tap choice
  always_comb begin
    strobes              = '0;
    strobes.loadSample   = dataEn;
    strobes.shiftCoef    = coefEn;
    strobes.sampleSigned = sampleSigned;
    strobes.coefSigned   = coefSigned;
    for (int k = 0; k < DEC_STAGES; k++) begin
      strobes.tapSel[k] = (decSel == SEL_W'(k));
    end
  end
endmodule

// File: rtl/firMacCell.sv
module firMacCell
  import firCellPkg::*;
#(
  parameter int ACC_W = 26
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  shiftCoef,
  input  logic                  sampleSigned,
  input  logic                  coefSigned,
  input  logic [DEC_STAGES-1:0] tapSel,
  input  logic                  clear,
  input  logic [OPND_W-1:0]     sampleQ,
  input  logic [OPND_W-1:0]     coefChainIn,
  output logic [OPND_W-1:0]     coefTap,
  output logic [OPND_W-1:0]     coefFwd,
  output logic [ACC_W-1:0]      acc
);
  localparam int EXT_W = ACC_W - PROD_W;

  logic [OPND_W-1:0]        dly [DEC_STAGES];
  logic signed [OPND_W-1:0] opA, opB;
  logic signed [PROD_W-1:0] prod;
  logic [ACC_W-1:0]         prodExt, sum;
  logic                     ovf;

  // coefficient resampling chain
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEC_STAGES; k++) dly[k] <= '0;
    end else if (shiftCoef) begin
      dly[0] <= coefChainIn;
      for (int k = 1; k < DEC_STAGES; k++) dly[k] <= dly[k-1];
    end
  end

  assign coefTap = dly[0];

  always_comb begin
    coefFwd = '0;
    for (int k = 0; k < DEC_STAGES; k++) begin
      if (tapSel[k]) coefFwd = dly[k];
    end
  end

  // operand formatting and multiply
  assign opA     = sampleSigned ? sampleQ : {1'b0, sampleQ[OPND_W-2:0]};
  assign opB     = coefSigned   ? dly[0]  : {1'b0, dly[0][OPND_W-2:0]};
  assign prod    = opA * opB;
  assign prodExt = {{EXT_W{prod[PROD_W-1]}}, prod};
  assign sum     = acc + prodExt;
  assign ovf     = (acc[ACC_W-1] == prodExt[ACC_W-1]) && (sum[ACC_W-1] != acc[ACC_W-1]);

  always_ff @(posedge clk) begin
    if (rst)        acc <= '0;
    else if (clear) acc <= prodExt;
    else            acc <= sum;
  end

  AST_COEF_HOLD: assert property (@(posedge clk) disable iff (rst)
    !shiftCoef |=> ($stable(dly[0]) && $stable(dly[DEC_STAGES-1]))); // R7
  AST_UNSIGNED_NONNEG: assert property (@(posedge clk) disable iff (rst)
    (!sampleSigned && !coefSigned) |-> !prod[PROD_W-1]); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    !clear |-> !ovf); // R10
endmodule

// File: rtl/firCellDatapath.sv
module firCellDatapath
  import firCellPkg::*;
#(
  parameter int NUM_CELLS = 8,
  parameter int ACC_W     = 26
) (
  input  logic                       clk,
  input  logic                       rst,
  input  cellStrobes_t               strobes,
  input  logic [NUM_CELLS-1:0]       accClear,
  input  logic [OPND_W-1:0]          sampleIn,
  input  logic [OPND_W-1:0]          coefIn,
  output logic [NUM_CELLS*ACC_W-1:0] accFlat,
  output logic [OPND_W-1:0]          coefCascade
);
  logic [OPND_W-1:0]                 sampleQ;
  logic [NUM_CELLS-1:0][OPND_W-1:0]  coefFwd;
  logic [NUM_CELLS-1:0][OPND_W-1:0]  coefTap;
  logic [NUM_CELLS-1:0][OPND_W-1:0]  chainIn;

  // one sample register broadcast to every cell
  always_ff @(posedge clk) begin
    if (rst)                     sampleQ <= '0;
    else if (strobes.loadSample) sampleQ <= sampleIn;
  end

  AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobes.loadSample |=> $stable(sampleQ)); // R6

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    if (i == 0) begin : g_head
      assign chainIn[i] = coefIn;
    end else begin : g_link
      assign chainIn[i] = coefFwd[i-1];
      AST_FWD_LINK: assert property (@(posedge clk) disable iff (rst)
        strobes.shiftCoef |=> (coefTap[i] == $past(coefFwd[i-1]))); // R8
    end

    firMacCell #(.ACC_W(ACC_W)) u_cell (
      .clk          (clk),
      .rst          (rst),
      .shiftCoef    (strobes.shiftCoef),
      .sampleSigned (strobes.sampleSigned),
      .coefSigned   (strobes.coefSigned),
      .tapSel       (strobes.tapSel),
      .clear        (accClear[i]),
      .sampleQ      (sampleQ),
      .coefChainIn  (chainIn[i]),
      .coefTap      (coefTap[i]),
      .coefFwd      (coefFwd[i]),
      .acc          (accFlat[i*ACC_W +: ACC_W])
    );
  end

  assign coefCascade = coefFwd[NUM_CELLS-1];
endmodule

// File: rtl/firCellArray.sv
module firCellArray
  import firCellPkg::*;
#(
  parameter int NUM_CELLS = 8,
  parameter int ACC_W     = 26
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [OPND_W-1:0]          sampleIn,
  input  logic [OPND_W-1:0]          coefIn,
  input  logic                       sampleSigned,
  input  logic                       coefSigned,
  input  logic                       dataEn,
  input  logic                       coefEn,
  input  logic [SEL_W-1:0]           decSel,
  input  logic [NUM_CELLS-1:0]       accClear,
  output logic [NUM_CELLS*ACC_W-1:0] accOut,
  output logic [OPND_W-1:0]          coefCascade
);
  cellStrobes_t strobes;

  firCellCtrl u_ctrl (
    .dataEn       (dataEn),
    .coefEn       (coefEn),
    .sampleSigned (sampleSigned),
    .coefSigned   (coefSigned),
    .decSel       (decSel),
    .strobes      (strobes)
  );

  firCellDatapath #(.NUM_CELLS(NUM_CELLS), .ACC_W(ACC_W)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobes     (strobes),
    .accClear    (accClear),
    .sampleIn    (sampleIn),
    .coefIn      (coefIn),
    .accFlat     (accOut),
    .coefCascade (coefCascade)
  );
endmodule

// File: tb/firCellArray_tb.sv
module firCellArray_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 8;
  localparam int AW = 26;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          rst = 1'b1;
  logic [8:0]    sampleIn = '0, coefIn = '0;
  logic          sampleSigned = 1'b0, coefSigned = 1'b0;
  logic          dataEn = 1'b0, coefEn = 1'b0;
  logic [1:0]    decSel = '0;
  logic [NC-1:0] accClear = '0;
  logic [NC*AW-1:0] accOut;
  logic [8:0]    coefCascade;

  firCellArray #(.NUM_CELLS(NC), .ACC_W(AW)) u_dut (
    .clk(clk), .rst(rst), .sampleIn(sampleIn), .coefIn(coefIn),
    .sampleSigned(sampleSigned), .coefSigned(coefSigned),
    .dataEn(dataEn), .coefEn(coefEn), .decSel(decSel),
    .accClear(accClear), .accOut(accOut), .coefCascade(coefCascade)
  );

  typedef struct {
    logic [NC*AW-1:0] acc;
    logic [8:0]       casc;
    string            tag;
  } expItem_t;

  expItem_t sbQ[$];
  int checks = 0;
  int failures = 0;

  // reference state, built from the requirements
  logic [8:0]    mSample;
  logic [8:0]    mDly [NC][4];
  logic [AW-1:0] mAcc [NC];

  function automatic logic signed [17:0] refProd(input logic [8:0] s, input logic [8:0] c,
                                                 input logic ss, input logic cs);
    logic signed [8:0] a, b;
    a = ss ? s : {1'b0, s[7:0]};   // R3 unsigned uses bits 7:0
    b = cs ? c : {1'b0, c[7:0]};   // R2 signed uses bit 8 as sign
    return a * b;
  endfunction

  task automatic drive(input logic r, input logic [8:0] s, input logic [8:0] c,
                       input logic ss, input logic cs, input logic de, input logic ce,
                       input logic [1:0] ds, input logic [NC-1:0] clr, input string tag);
    expItem_t it;
    logic [8:0] oldFwd [NC];
    logic signed [17:0] p;
    @(negedge clk);
    rst = r; sampleIn = s; coefIn = c; sampleSigned = ss; coefSigned = cs;
    dataEn = de; coefEn = ce; decSel = ds; accClear = clr;
    for (int i = 0; i < NC; i++) oldFwd[i] = mDly[i][ds];
    if (r) begin
      mSample = '0;
      for (int i = 0; i < NC; i++) begin
        mAcc[i] = '0;
        for (int k = 0; k < 4; k++) mDly[i][k] = '0;
      end
    end else begin
      for (int i = 0; i < NC; i++) begin
        p = refProd(mSample, mDly[i][0], ss, cs);
        if (clr[i]) mAcc[i] = {{(AW-18){p[17]}}, p};
        else        mAcc[i] = mAcc[i] + {{(AW-18){p[17]}}, p};
      end
      if (de) mSample = s;
      if (ce) begin
        for (int i = 0; i < NC; i++) begin
          for (int k = 3; k > 0; k--) mDly[i][k] = mDly[i][k-1];
          mDly[i][0] = (i == 0) ? c : oldFwd[i-1];
        end
      end
    end
    for (int i = 0; i < NC; i++) it.acc[i*AW +: AW] = mAcc[i];
    it.casc = mDly[NC-1][ds];
    it.tag = tag;
    sbQ.push_back(it);
  endtask

  // monitor: compare after each rising edge
  initial begin
    forever begin
      expItem_t it;
      @(posedge clk);
      #1;
      if (sbQ.size() > 0) begin
        it = sbQ.pop_front();
        checks++;
        if (accOut !== it.acc) begin
          failures++;
          $display("FAIL %s accOut actual=%h expected=%h", it.tag, accOut, it.acc);
        end
        checks++;
        if (coefCascade !== it.casc) begin
          failures++;
          $display("FAIL %s coefCascade actual=%h expected=%h", it.tag, coefCascade, it.casc);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic logic [8:0] rnd9();
    return 9'($urandom);
  endfunction

  initial begin
    logic [NC-1:0] all1;
    all1 = '1;
    // R1: reset from start, then reset in mid-run
    for (int k = 0; k < 3; k++) drive(1, 0, 0, 0, 0, 0, 0, 0, '0, "R1");
    for (int k = 0; k < 6; k++) drive(0, rnd9(), rnd9(), 1, 1, 1, 1, 1, '0, "R1");
    drive(1, rnd9(), rnd9(), 1, 1, 1, 1, 1, '0, "R1");
    // R2: both operands signed
    for (int k = 0; k < 40; k++) drive(0, rnd9(), rnd9(), 1, 1, 1, 1, 0, (k == 0) ? all1 : '0, "R2");
    // R3: bit 8 set on the unsigned operand, modes independent
    for (int k = 0; k < 30; k++) drive(0, {1'b1, 8'($urandom)}, rnd9(), 0, 1, 1, 1, 0, (k == 0) ? all1 : '0, "R3");
    for (int k = 0; k < 30; k++) drive(0, rnd9(), {1'b1, 8'($urandom)}, 1, 0, 1, 1, 0, (k == 0) ? all1 : '0, "R3");
    for (int k = 0; k < 30; k++) drive(0, 9'h1FF, 9'h1FF, 0, 0, 1, 1, 0, (k == 0) ? all1 : '0, "R3");
    // R4: plain accumulation
    for (int k = 0; k < 40; k++) drive(0, rnd9(), rnd9(), 1, 1, 1, 1, 0, (k == 0) ? all1 : '0, "R4");
    // R5: rotating per-cell clear
    for (int k = 0; k < 48; k++) drive(0, rnd9(), rnd9(), 1, 0, 1, 1, 0, NC'(1) << (k % NC), "R5");
    // R6: sample enable toggling
    for (int k = 0; k < 40; k++) drive(0, rnd9(), rnd9(), 1, 1, (k % 3) == 0, 1, 0, (k == 0) ? all1 : '0, "R6");
    // R7: coefficient chain paused on odd cycles
    for (int k = 0; k < 40; k++) drive(0, rnd9(), rnd9(), 1, 1, 1, (k % 2) == 0, 2, (k == 0) ? all1 : '0, "R7");
    // R8: each longer delay setting
    for (int d = 1; d < 4; d++)
      for (int k = 0; k < 40; k++) drive(0, rnd9(), rnd9(), 1, 1, 1, 1, 2'(d), (k == 0) ? all1 : '0, "R8");
    // R9: impulse through all cells at four stages each, with a pause
    for (int k = 0; k < 40; k++) drive(0, 0, 0, 1, 1, 1, 1, 3, '0, "R9");
    for (int k = 0; k < 40; k++) drive(0, rnd9(), (k == 0) ? 9'h0AB : 9'h000, 1, 1, 1, (k != 10), 3, (k == 0) ? all1 : '0, "R9");
    // R10: largest-magnitude product for 500 edges
    for (int k = 0; k < 500; k++) drive(0, 9'h100, 9'h100, 1, 1, 1, 1, 0, (k == 0) ? all1 : '0, "R10");
    drive(0, 9'h100, 9'h100, 1, 1, 1, 1, 0, all1, "R10");
    @(posedge clk);
    #2;
    @(posedge clk);
    #2;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule